// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel NOR-style flash device. Once software or another engine has launched a program or erase operation, it pulses `start_i` with the address of the status location. The poller then reads the status byte over a simple request/valid read port. It watches one status bit that flips on every read while the device is busy, plus a second bit that the device raises when its internal operation runs past its time limit.

Reads are made in pairs. If the watched bit holds its value across a pair, the operation has ended and the poller reports success. If the bit is still flipping and the time-limit bit is clear, another pair follows. If the time-limit bit is set, one more pair is read to confirm the outcome. Toggling may have stopped in the same instant that the limit bit rose, so that pair can still yield success. If the bit still flips, the poller writes a reset command to put the device back in array-read mode and reports failure. A pair budget sets a bound on the wait, so a device that never settles still yields a result.

Top module: `tbp_ctrl`

## Requirements
- R1: With the block idle, a `start_i` pulse makes `busy_o` high on the next cycle and raises `rd_req_o` at once for the first status read. `busy_o` stays high until the cycle after `done_o`.
- R2: Status bit 6 is the toggle bit. If bit 6 is equal in the two reads of a pair, the block raises `done_o` with `pass_o`=1 and issues no further read. All other bits of those reads are ignored.
- R3: If bit 6 differs within a pair and bit 5 of the second read of that pair is 0, the block issues a fresh pair of reads. The comparison restarts from the first read of the new pair.
- R4: If bit 6 differs and bit 5 of the second read is 1, the block issues exactly two more reads. If bit 6 is equal across those two reads, the result is `pass_o`=1.
- R5: If bit 6 still differs across the confirming pair, the block holds `cmd_req_o` with `cmd_data_o`=RESET_CMD (0xF0 by default) at the status address until `cmd_ack_i`. The cycle after the acknowledge it pulses `done_o` with `pass_o`=0.
- R6: After MAX_POLLS pairs that each toggle with bit 5 clear, the block stops polling and takes the failure path of R5.
- R7: `done_o` is high for exactly one cycle per operation. `pass_o` keeps its value until the next accepted start, which clears it.
- R8: A `start_i` pulse while `busy_o` is high has no effect: the read count, the read address and the outcome of the running operation are unchanged.
- R9: `rd_req_o` stays high until `rd_valid_i` is returned. `rd_req_o` and `cmd_req_o` are never high together. `rd_addr_o` and `cmd_addr_o` carry the `status_addr_i` value captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin polling (accepted only when idle) |
| status_addr_i | input | ADDR_W | Address of the status location, captured at start |
| busy_o | output | 1 | Polling sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result of last operation (1 = success) |
| rd_req_o | output | 1 | Status read request, held until valid |
| rd_addr_o | output | ADDR_W | Status read address |
| rd_data_i | input | DATA_W | Returned status byte |
| rd_valid_i | input | 1 | Read data valid, one cycle |
| cmd_req_o | output | 1 | Reset-command write request, held until acknowledge |
| cmd_addr_o | output | ADDR_W | Reset-command address |
| cmd_data_o | output | DATA_W | Reset-command value |
| cmd_ack_i | input | 1 | Command write accepted |

## Verification
The bench goes after the race case, where bit 5 is set while bit 6 still flips but the confirming pair is steady. A design that fails on the first sight of bit 5 would report failure and write a needless reset there. It feeds pairs in which bit 5 is set only in the first read, to catch a design that samples the limit bit from the wrong read. Its pair sequences flip bit 6 across pair boundaries, to catch a design that compares against a stale stored value instead of the first read of each pair. It also spends the whole pair budget, to expose an off-by-one in the limit. Stray start pulses and a changing status address during an operation expose a controller that restarts or re-captures while busy.

// File: rtl/tbp_pkg.sv
// Shared types for the toggle-bit poller.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package tbp_pkg;

    // Controller sequencing states: one read-pair phase, one confirming pair,
    // the recovery command and a one-cycle completion state.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_CF_A,
        ST_CF_B,
        ST_CMD,
        ST_FIN
    } tbp_state_e;

endpackage

// File: rtl/tbp_toggle_track.sv
// Holds the toggle bit of the first read of a pair and flags whether the
// second read's toggle bit differs; also exposes the time-limit bit of the
// byte currently on the read bus.
// Assumes: data_i is meaningful only in a cycle where the caller sees valid.
module tbp_toggle_track #(
    parameter int DATA_W      = 8,
    parameter int TOGGLE_BIT  = 6,
    parameter int TIMEOUT_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              toggled_o,
    output logic              timeout_o
);

    logic ref_q;

    // Remember the toggle bit from the first read of a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
        end else if (capture_i) begin
            ref_q <= data_i[TOGGLE_BIT];
        end
    end

    // Toggle detection is a plain XOR of stored and fresh bit.
    assign toggled_o = ref_q ^ data_i[TOGGLE_BIT];
    assign timeout_o = data_i[TIMEOUT_BIT];

    AST_STATUS_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> !$isunknown(data_i)) else $error("status byte unknown"); // R2

    AST_CAPTURE_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |-> valid_i) else $error("capture without valid"); // R3

endmodule

// File: rtl/tbp_poll_limit.sv
// Counts read pairs that ended still toggling with the limit bit clear and
// flags the last pair the budget allows.
// Assumes: MAX_POLLS >= 1; clear_i and inc_i are never high together.
module tbp_poll_limit #(
    parameter int MAX_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic inc_i,
    output logic last_o
);

    localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt_q;

    // Pair counter, cleared on each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the final budgeted pair.
    assign last_o = (cnt_q == LAST);

    AST_NO_INC_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !last_o) else $error("pair budget overrun"); // R6

endmodule

// File: rtl/tbp_fsm.sv
// Sequencing for the poller: issues status reads in pairs, decides on each
// second read, runs the confirming pair after the limit bit, drives the
// reset-command write and produces the completion pulse and result.
// Assumes: rd_valid_i only answers a held rd_req_o; cmd_ack_i only answers
// a held cmd_req_o.
module tbp_fsm
    import tbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic rd_valid_i,
    input  logic cmd_ack_i,
    input  logic toggled_i,
    input  logic timeout_i,
    input  logic poll_last_i,
    output logic accept_o,
    output logic capture_o,
    output logic poll_inc_o,
    output logic busy_o,
    output logic rd_req_o,
    output logic cmd_req_o,
    output logic done_o,
    output logic pass_o
);

    tbp_state_e st_q, st_d;
    logic       pass_q, pass_d;

    // Next-state and result decision.
    always_comb begin
        st_d   = st_q;
        pass_d = pass_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d   = ST_RD_A;
                    pass_d = 1'b0;
                end
            end
            ST_RD_A: begin
                if (rd_valid_i) st_d = ST_RD_B;
            end
            ST_RD_B: begin
                if (rd_valid_i) begin
                    if (!toggled_i) begin
                        st_d   = ST_FIN;
                        pass_d = 1'b1;
                    end else if (timeout_i) begin
                        st_d = ST_CF_A;
                    end else if (poll_last_i) begin
                        st_d = ST_CMD;
                    end else begin
                        st_d = ST_RD_A;
                    end
                end
            end
            ST_CF_A: begin
                if (rd_valid_i) st_d = ST_CF_B;
            end
            ST_CF_B: begin
                if (rd_valid_i) begin
                    if (!toggled_i) begin
                        st_d   = ST_FIN;
                        pass_d = 1'b1;
                    end else begin
                        st_d = ST_CMD;
                    end
                end
            end
            ST_CMD: begin
                if (cmd_ack_i) st_d = ST_FIN;
            end
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pass_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pass_q <= pass_d;
        end
    end

    // Control strobes to the datapath pieces.
    assign accept_o   = (st_q == ST_IDLE) && start_i;
    assign capture_o  = rd_valid_i && ((st_q == ST_RD_A) || (st_q == ST_CF_A));
    assign poll_inc_o = (st_q == ST_RD_B) && rd_valid_i && toggled_i
                        && !timeout_i && !poll_last_i;

    // Port-facing outputs decoded from state.
    assign rd_req_o  = (st_q == ST_RD_A) || (st_q == ST_RD_B)
                     || (st_q == ST_CF_A) || (st_q == ST_CF_B);
    assign cmd_req_o = (st_q == ST_CMD);
    assign done_o    = (st_q == ST_FIN);
    assign busy_o    = (st_q != ST_IDLE);
    assign pass_o    = pass_q;

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && rd_req_o)) else $error("start not taken"); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R7

    AST_PASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(pass_o)) else $error("result changed while idle"); // R7

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && cmd_req_o)) else $error("read and command together"); // R9

    AST_RDREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i) |=> rd_req_o) else $error("read request dropped"); // R9

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req_o && !cmd_ack_i) |=> cmd_req_o) else $error("command request dropped"); // R5

    AST_FAIL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req_o && cmd_ack_i) |=> (done_o && !pass_o)) else $error("failure not reported"); // R5

endmodule

// File: rtl/tbp_ctrl.sv
// Top of the toggle-bit poller. Captures the status address at start, wires
// the sequencer to the toggle tracker and the pair budget, and presents the
// read port and the reset-command write port.
// Assumes: one outstanding read at a time; the command port accepts with a
// single-cycle acknowledge.
module tbp_ctrl #(
    parameter int              ADDR_W      = 24,
    parameter int              DATA_W      = 8,
    parameter int              TOGGLE_BIT  = 6,
    parameter int              TIMEOUT_BIT = 5,
    parameter int              MAX_POLLS   = 1000,
    parameter logic [DATA_W-1:0] RESET_CMD = DATA_W'('hF0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] status_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              rd_valid_i,
    output logic              cmd_req_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [DATA_W-1:0] cmd_data_o,
    input  logic              cmd_ack_i
);

    logic              accept;
    logic              capture;
    logic              poll_inc;
    logic              toggled;
    logic              timeout;
    logic              poll_last;
    logic [ADDR_W-1:0] addr_q;

    // Latch the status address once per accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= status_addr_i;
        end
    end

    assign rd_addr_o  = addr_q;
    assign cmd_addr_o = addr_q;
    assign cmd_data_o = RESET_CMD;

    tbp_toggle_track #(
        .DATA_W      (DATA_W),
        .TOGGLE_BIT  (TOGGLE_BIT),
        .TIMEOUT_BIT (TIMEOUT_BIT)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .valid_i   (rd_valid_i),
        .data_i    (rd_data_i),
        .toggled_o (toggled),
        .timeout_o (timeout)
    );

    tbp_poll_limit #(
        .MAX_POLLS (MAX_POLLS)
    ) u_limit (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .inc_i   (poll_inc),
        .last_o  (poll_last)
    );

    tbp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .rd_valid_i  (rd_valid_i),
        .cmd_ack_i   (cmd_ack_i),
        .toggled_i   (toggled),
        .timeout_i   (timeout),
        .poll_last_i (poll_last),
        .accept_o    (accept),
        .capture_o   (capture),
        .poll_inc_o  (poll_inc),
        .busy_o      (busy_o),
        .rd_req_o    (rd_req_o),
        .cmd_req_o   (cmd_req_o),
        .done_o      (done_o),
        .pass_o      (pass_o)
    );

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(rd_addr_o)) else $error("address moved while busy"); // R8

endmodule

// File: tb/tbp_ctrl_tb.sv
`timescale 1ns/1ps
module tbp_ctrl_tb;

    localparam int AW      = 24;
    localparam int DW      = 8;
    localparam int TB_MAX  = 4;
    localparam logic [DW-1:0] RST_CMD = 8'hF0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] status_addr_i = '0;
    logic          busy_o, done_o, pass_o, rd_req_o, cmd_req_o;
    logic [AW-1:0] rd_addr_o, cmd_addr_o;
    logic [DW-1:0] cmd_data_o;
    logic [DW-1:0] rd_data_i = 8'hA5;
    logic          rd_valid_i = 1'b0;
    logic          cmd_ack_i = 1'b0;

    always #2 clk = ~clk;

    tbp_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .TOGGLE_BIT(6), .TIMEOUT_BIT(5),
        .MAX_POLLS(TB_MAX), .RESET_CMD(RST_CMD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .status_addr_i(status_addr_i),
        .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .rd_valid_i(rd_valid_i), .cmd_req_o(cmd_req_o), .cmd_addr_o(cmd_addr_o),
        .cmd_data_o(cmd_data_o), .cmd_ack_i(cmd_ack_i)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] stream[$];
    int         exp_n = 0;
    bit         exp_pass = 0;
    int         rd_lat = 0;

    // Reference model state (behavioural, driven by the same port events)
    bit            m_busy, m_fin, m_pass;
    int            m_served;
    logic [AW-1:0] m_addr;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Outcome prediction from the requirement text, over a copy of the stream.
    task automatic predict();
        int i = 0;
        int pairs = 0;
        logic [7:0] a, b;
        exp_pass = 0;
        while (1) begin
            if (i + 1 >= stream.size()) begin exp_pass = 0; break; end
            a = stream[i]; b = stream[i+1]; i += 2;
            if (a[6] == b[6]) begin exp_pass = 1; break; end        // R2
            if (b[5]) begin                                          // R4
                if (i + 1 >= stream.size()) break;
                a = stream[i]; b = stream[i+1]; i += 2;
                exp_pass = (a[6] == b[6]);
                break;
            end
            pairs++;                                                 // R3
            if (pairs == TB_MAX) begin exp_pass = 0; break; end      // R6
        end
        exp_n = i;
    endtask

    // Reference model advanced on each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_fin <= 0; m_pass <= 0; m_served <= 0; m_addr <= '0;
        end else if (m_fin) begin
            m_fin <= 0; m_busy <= 0;
        end else if (!m_busy) begin
            if (start_i) begin
                m_busy <= 1; m_served <= 0; m_pass <= 0; m_addr <= status_addr_i;
            end
        end else begin
            if (rd_valid_i && m_served < exp_n) begin
                m_served <= m_served + 1;
                if (m_served + 1 == exp_n && exp_pass) begin
                    m_fin <= 1; m_pass <= 1;
                end
            end
            if (cmd_ack_i && m_served == exp_n && !exp_pass) m_fin <= 1;
        end
    end

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy_o === m_busy, "R1", "busy_o", busy_o, m_busy);
            chk(done_o === m_fin, "R7", "done_o", done_o, m_fin);
            chk(pass_o === m_pass, "R7", "pass_o", pass_o, m_pass);
            chk(rd_req_o === (m_busy && !m_fin && m_served < exp_n), "R3", "rd_req_o",
                rd_req_o, (m_busy && !m_fin && m_served < exp_n));
            chk(cmd_req_o === (m_busy && !m_fin && m_served == exp_n && !exp_pass), "R5",
                "cmd_req_o", cmd_req_o, (m_busy && !m_fin && m_served == exp_n && !exp_pass));
            if (rd_req_o) chk(rd_addr_o === m_addr, "R9", "rd_addr_o", rd_addr_o, m_addr);
            if (cmd_req_o) begin
                chk(cmd_addr_o === m_addr, "R9", "cmd_addr_o", cmd_addr_o, m_addr);
                chk(cmd_data_o === RST_CMD, "R5", "cmd_data_o", cmd_data_o, RST_CMD);
            end
        end
    end

    // Read responder: answers each held request after rd_lat idle cycles.
    bit rd_pend = 0;
    int rd_wait = 0;
    always @(negedge clk) begin
        rd_valid_i = 1'b0;
        rd_data_i  = 8'hA5;
        if (!rst_n) begin
            rd_pend = 0;
        end else if (rd_pend) begin
            if (rd_wait == 0) begin
                rd_valid_i = 1'b1;
                rd_data_i  = (stream.size() > 0) ? stream.pop_front() : 8'h00;
                rd_pend    = 0;
            end else begin
                rd_wait--;
            end
        end else if (rd_req_o) begin
            rd_pend = 1;
            rd_wait = rd_lat;
        end
    end

    // Command responder: acknowledges a held command after one idle cycle.
    int ack_wait = 0;
    always @(negedge clk) begin
        cmd_ack_i = 1'b0;
        if (rst_n && cmd_req_o) begin
            if (ack_wait == 1) begin
                cmd_ack_i = 1'b1;
                ack_wait  = 0;
            end else begin
                ack_wait++;
            end
        end else begin
            ack_wait = 0;
        end
    end

    task automatic push2(input logic [7:0] a, input logic [7:0] b);
        stream.push_back(a);
        stream.push_back(b);
    endtask

    task automatic run_op(input string req, input int lat, input logic [AW-1:0] addr,
                          input bit stray_start);
        predict();
        rd_lat = lat;
        @(negedge clk);
        status_addr_i = addr;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (stray_start) begin
            repeat (2) @(negedge clk);
            status_addr_i = ~addr;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (m_busy) @(negedge clk);
        chk(stream.size() == 0, req, "unread status bytes", stream.size(), 0);
        chk(pass_o === exp_pass, req, "final pass_o", pass_o, exp_pass);
        repeat (2) @(negedge clk);
        chk(pass_o === exp_pass, "R7", "pass_o held", pass_o, exp_pass);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(busy_o === 1'b0, "R1", "reset busy_o", busy_o, 0);
        chk(done_o === 1'b0, "R7", "reset done_o", done_o, 0);
        chk(pass_o === 1'b0, "R7", "reset pass_o", pass_o, 0);
        chk(rd_req_o === 1'b0 && cmd_req_o === 1'b0, "R9", "reset requests",
            {rd_req_o, cmd_req_o}, 0);

        // R2: steady toggle bit, both polarities, other bits differing
        push2(8'h40, 8'h40);           run_op("R2", 0, 24'h000100, 0);
        push2(8'h9F, 8'h1F);           run_op("R2", 1, 24'h000200, 0);

        // R3: toggling with limit clear, several pairs, bit 6 flips across pairs
        push2(8'h40, 8'h00); push2(8'h00, 8'h40); push2(8'h40, 8'h40);
        run_op("R3", 2, 24'h000300, 0);
        // R3: limit bit only in first read of a pair is not acted upon
        push2(8'h60, 8'h00); push2(8'h00, 8'h00);
        run_op("R3", 0, 24'h000400, 0);

        // R4: limit bit seen, confirming pair steady -> success
        push2(8'h00, 8'h60); push2(8'h40, 8'h40);
        run_op("R4", 1, 24'h000500, 0);

        // R5: limit bit seen, confirming pair still toggles -> reset command
        push2(8'h00, 8'h60); push2(8'h60, 8'h20);
        run_op("R5", 0, 24'h000600, 0);

        // R6: pair budget exhausted
        for (int k = 0; k < TB_MAX; k++) push2(8'h00, 8'h40);
        run_op("R6", 1, 24'h000700, 0);

        // R7: pass cleared by the next start after a failure, then success
        push2(8'h00, 8'h00);           run_op("R7", 0, 24'h000800, 0);

        // R8: stray start and address change while busy are ignored
        push2(8'h40, 8'h00); push2(8'h00, 8'h40); push2(8'h00, 8'h00);
        run_op("R8", 2, 24'h000900, 1);
        push2(8'h00, 8'h60); push2(8'h40, 8'h00);
        run_op("R8", 1, 24'h000A00, 1);

        finish_run();
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule